// File: doc/BRIEF.md
# Gated Auto-Reload Timer with Toggle Output

An 8-bit up-counter that reloads itself from a software-written value each time it rolls over from 0xFF. Each count step comes from one of two sources. The first is an internal tick that divides the system clock by 1, 4, 16 or 64. The second is a rising edge on an external clock pin, which is synchronized to the system clock. A gate pin, once enabled, lets count steps through only while it is high.

At every rollover the block does three things. It emits a one-cycle overflow strobe that other units, such as PWM or serial shifters, can use as a tick. It raises an interrupt when that is enabled. It inverts a waveform pin, so the pin carries a square wave whose period is two overflow intervals.

Software uses a small register port with a write strobe and a combinational read mux. The port holds the reload value and the control fields, and it lets software read back the live count.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset, the reload value, control word and count all read 0, and ovf_o, irq_o and wave_o are 0.
- R2: With run = ctrl bit 0 set and ext select = ctrl bit 3 clear, the count advances once every 1, 4, 16 or 64 clocks for a divider code (ctrl bits 2:1) of 0, 1, 2 or 3. The divider restarts whenever run is clear, and the first step follows N clocks after run takes effect.
- R3: A count step taken at 0xFF loads the reload register (address 0) into the count instead of incrementing. ovf_o is high for exactly the cycle after that step.
- R4: wave_o inverts on every overflow while running, so its period equals two overflow intervals.
- R5: With ext select set, the count advances exactly once for each rising edge of ext_clk_i, three clocks after the edge is sampled. Falling edges and steady levels cause no step.
- R6: With gate enable (ctrl bit 4) set, count steps occur only while gate_i, delayed by two clocks of synchronization, is high. Steps are blocked while it is low.
- R7: Clearing run freezes the count and drives wave_o to 0 from the next cycle.
- R8: A write to address 0 while run is clear also loads the count. While running, the same write changes only the reload value.
- R9: irq_o equals ovf_o when irq enable (ctrl bit 5) is set, and is 0 otherwise.
- R10: Address 1 reads the control word with bits 7:6 as 0. Address 2 reads the count, and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| gate_i | input | 1 | Count gate, asynchronous |
| ovf_o | output | 1 | One-cycle overflow strobe |
| irq_o | output | 1 | Overflow interrupt |
| wave_o | output | 1 | Toggle-on-overflow waveform |

## Verification
The counter is driven from each internal divider setting in turn. This separates the four step intervals and shows the divider restarting when run is set again. Short reload windows near 0xFF force many rollovers, which shows the reload value is taken rather than zero and gives the waveform period. In external mode, pulse trains and one long high level show that only rising edges count. Gate toggling in fast internal mode shows the two-clock gate latency. Register writes made while stopped and while running show which of them touch the live count.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the gated auto-reload timer.
// Assumes an 8-bit data path for both the counter and the register port.
package tmr_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int CTRL_W = 6;

    localparam logic [AW-1:0] A_RELOAD = 2'd0;
    localparam logic [AW-1:0] A_CTRL   = 2'd1;
    localparam logic [AW-1:0] A_COUNT  = 2'd2;

    // Control word, packed to the register bit positions (bit 0 = run).
    typedef struct packed {
        logic       irq_en;   // bit 5
        logic       gate_en;  // bit 4
        logic       ext_sel;  // bit 3
        logic [1:0] div_sel;  // bits 2:1
        logic       run;      // bit 0
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
// Multi-stage synchronizer for asynchronous single-bit inputs.
// Assumes each input holds a level long enough to be caught by the flops.
module tmr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled levels along the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
// Produces the per-cycle count enable. It chooses either a power-of-four
// division of the system clock or a rising edge of the synchronized
// external clock, then qualifies the choice with run and the optional gate.
// Assumes ext_sync_i and gate_sync_i are already synchronized.
module tmr_tick_gen #(
    parameter int NUM_DIV   = 4,
    parameter int DIV_SHIFT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic [$clog2(NUM_DIV)-1:0] div_sel_i,
    input  logic                       ext_sel_i,
    input  logic                       ext_sync_i,
    input  logic                       gate_en_i,
    input  logic                       gate_sync_i,
    output logic                       en_o
);
    localparam int PRE_W = DIV_SHIFT * (NUM_DIV - 1);

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_DIV-1:0] taps;
    logic               ext_prev_q;
    logic               int_tick;
    logic               ext_rise;
    logic               src_tick;
    logic               gate_ok;

    // One tap per divider setting: tap g fires once every 2**(DIV_SHIFT*g) clocks.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
        if (g == 0) begin : g_full
            assign taps[g] = 1'b1;
        end else begin : g_div
            assign taps[g] = &pre_q[DIV_SHIFT*g-1:0];
        end
    end

    // Free-running prescaler, held at zero while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (!run_i) pre_q <= '0;
        else             pre_q <= pre_q + PRE_W'(1);
    end

    // Previous external level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b0;
        else        ext_prev_q <= ext_sync_i;
    end

    assign int_tick = taps[div_sel_i];
    assign ext_rise = ext_sync_i & ~ext_prev_q;
    assign src_tick = ext_sel_i ? ext_rise : int_tick;
    assign gate_ok  = ~gate_en_i | gate_sync_i;
    assign en_o     = run_i & src_tick & gate_ok;

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pre_q == '0)); // R2
    AST_EXT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel_i && en_o) |=> (!en_o || !ext_sel_i)); // R5
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && !gate_sync_i) |-> !en_o); // R6
endmodule

// File: rtl/tmr_count_core.sv
// Counter datapath: increments on enable, reloads on rollover from all
// ones, strobes overflow for one cycle and inverts the waveform output.
// Assumes load_i and en_i are never both set (load happens only when stopped).
module tmr_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         run_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o,
    output logic         wave_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;
    logic         ovf_q;
    logic         wave_q;
    logic         wrap;

    assign wrap = en_i && (cnt_q == CNT_MAX);

    // Count, reload on rollover, or take a direct load while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (load_i)    cnt_q <= load_val_i;
            else if (wrap) cnt_q <= reload_i;
            else if (en_i) cnt_q <= cnt_q + W'(1);
        end
    end

    // Waveform flips on every rollover, forced low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      wave_q <= 1'b0;
        else if (!run_i) wave_q <= 1'b0;
        else if (wrap)   wave_q <= ~wave_q;
    end

    assign cnt_o  = cnt_q;
    assign ovf_o  = ovf_q;
    assign wave_o = wave_q;

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_i))); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + W'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(cnt_q)); // R7
    AST_WAVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && en_i && cnt_q == CNT_MAX) |=> (wave_q != $past(wave_q))); // R4
    AST_WAVE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !wave_q); // R7
endmodule

// File: rtl/tmr_regs.sv
// Register file: reload value and control word, plus the read mux.
// Decodes a write to the reload address while stopped as a counter load.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] cnt_i,
    output logic [DW-1:0] reload_o,
    output tmr_ctrl_t     ctrl_o,
    output logic          load_o,
    output logic [DW-1:0] rd_data_o
);
    logic [DW-1:0] reload_q;
    tmr_ctrl_t     ctrl_q;

    // Capture register writes; the count address is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_RELOAD) reload_q <= wr_data_i;
            if (wr_addr_i == A_CTRL)   ctrl_q   <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    // Combinational read mux with zero padding.
    always_comb begin
        case (rd_addr_i)
            A_RELOAD: rd_data_o = reload_q;
            A_CTRL:   rd_data_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            A_COUNT:  rd_data_o = cnt_i;
            default:  rd_data_o = '0;
        endcase
    end

    assign load_o   = wr_en_i && (wr_addr_i == A_RELOAD) && !ctrl_q.run;
    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/gated_reload_timer.sv
// Top level of the gated auto-reload timer. It synchronizes the external
// clock and gate pins, builds the count enable, runs the counter and
// exposes the register port. Assumes one clock domain; pins are asynchronous.
module gated_reload_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [1:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    input  logic       ext_clk_i,
    input  logic       gate_i,
    output logic       ovf_o,
    output logic       irq_o,
    output logic       wave_o
);
    import tmr_pkg::*;

    localparam int NUM_DIV   = 4;
    localparam int DIV_SHIFT = 2;
    localparam int SYNC_STG  = 2;

    tmr_ctrl_t     ctrl;
    logic [DW-1:0] reload;
    logic [DW-1:0] cnt;
    logic          load;
    logic          en;
    logic          ovf;
    logic [1:0]    pin_sync;

    tmr_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({gate_i, ext_clk_i}),
        .sync_o  (pin_sync)
    );

    tmr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .cnt_i     (cnt),
        .reload_o  (reload),
        .ctrl_o    (ctrl),
        .load_o    (load),
        .rd_data_o (rd_data_o)
    );

    tmr_tick_gen #(.NUM_DIV(NUM_DIV), .DIV_SHIFT(DIV_SHIFT)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (ctrl.run),
        .div_sel_i   (ctrl.div_sel),
        .ext_sel_i   (ctrl.ext_sel),
        .ext_sync_i  (pin_sync[0]),
        .gate_en_i   (ctrl.gate_en),
        .gate_sync_i (pin_sync[1]),
        .en_o        (en)
    );

    tmr_count_core #(.W(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .run_i      (ctrl.run),
        .load_i     (load),
        .load_val_i (wr_data_i),
        .reload_i   (reload),
        .cnt_o      (cnt),
        .ovf_o      (ovf),
        .wave_o     (wave_o)
    );

    assign ovf_o = ovf;
    assign irq_o = ovf & ctrl.irq_en;

    AST_OVF_SINGLE_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(en)); // R3
endmodule

// File: tb/gated_reload_timer_bench.sv
module gated_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd2;
    logic       ext_clk = 1'b0;
    logic       gate = 1'b0;
    logic [7:0] rd_data;
    logic       ovf, irq, wave;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    int m_reload, m_ctrl, m_cnt, m_wave, m_ovf, m_pre;
    int m_e1, m_e2, m_ep, m_g1, m_g2;

    always #10 clk = ~clk;

    gated_reload_timer u_gated_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ext_clk_i(ext_clk), .gate_i(gate), .ovf_o(ovf), .irq_o(irq), .wave_o(wave)
    );

    // Behavioural model advanced at each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reload = 0; m_ctrl = 0; m_cnt = 0; m_wave = 0; m_ovf = 0; m_pre = 0;
            m_e1 = 0; m_e2 = 0; m_ep = 0; m_g1 = 0; m_g2 = 0;
        end else begin
            int run, divn, step, gate_ok;
            run = m_ctrl & 1;
            divn = 1 << (2 * ((m_ctrl >> 1) & 3));
            if ((m_ctrl >> 3) & 1) step = (m_e2 == 1 && m_ep == 0) ? 1 : 0;
            else step = ((m_pre % divn) == divn - 1) ? 1 : 0;
            gate_ok = (((m_ctrl >> 4) & 1) == 0 || m_g2 == 1) ? 1 : 0;
            step = run & step & gate_ok;
            m_ovf = (step == 1 && m_cnt == 255) ? 1 : 0;
            if (run == 0) m_wave = 0;
            else if (m_ovf == 1) m_wave = 1 - m_wave;
            if (wr_en && wr_addr == 2'd0 && run == 0) m_cnt = wr_data;
            else if (m_ovf == 1) m_cnt = m_reload;
            else if (step == 1) m_cnt = m_cnt + 1;
            m_pre = (run == 1) ? (m_pre + 1) % 64 : 0;
            m_ep = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
            m_g2 = m_g1; m_g1 = gate;
            if (wr_en && wr_addr == 2'd0) m_reload = wr_data;
            if (wr_en && wr_addr == 2'd1) m_ctrl = wr_data & 8'h3F;
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_reload;
            2'd1: return m_ctrl;
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every cycle, just after the edge, against the model.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check(cur_req, "rd_data", int'(rd_data), exp_rd(rd_addr));
            check(cur_req, "ovf_o", int'(ovf), m_ovf);
            check(cur_req, "wave_o", int'(wave), m_wave);
            check("R9", "irq_o", int'(irq), m_ovf & ((m_ctrl >> 5) & 1));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
        @(negedge clk);
        rd_addr = 2'd2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, c0, t0, t1, nirq;
        idle(3);
        rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        read_at(2'd0, v); check("R1", "reload after reset", v, 0);
        read_at(2'd1, v); check("R1", "ctrl after reset", v, 0);
        read_at(2'd2, v); check("R1", "count after reset", v, 0);
        check("R1", "wave after reset", int'(wave), 0);
        check("R1", "ovf after reset", int'(ovf), 0);

        // R8: write while stopped loads count
        cur_req = "R8";
        wr(2'd0, 8'h37);
        read_at(2'd2, v); check("R8", "stopped reload write loads count", v, 8'h37);

        // R2: each divider setting
        for (int d = 0; d < 4; d++) begin
            cur_req = "R2";
            wr(2'd0, 8'hF0);
            wr(2'd1, 8'(d << 1) | 8'h01);
            idle(40 + 70 * d);
            wr(2'd1, 8'h00);
            idle(3);
        end

        // R3 R4 R9: fast rollovers with short reload window
        cur_req = "R3";
        wr(2'd0, 8'hFC);
        wr(2'd1, 8'h21);
        nirq = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) nirq++;
        end
        check("R9", "irq pulses seen", (nirq >= 9) ? 1 : 0, 1);
        cur_req = "R4";
        @(negedge clk);
        while (!(wave == 1'b1)) @(negedge clk);
        while (!(wave == 1'b0)) @(negedge clk);
        while (!(wave == 1'b1)) @(negedge clk);
        t0 = $time;
        while (!(wave == 1'b0)) @(negedge clk);
        while (!(wave == 1'b1)) @(negedge clk);
        t1 = $time;
        check("R4", "wave period in clocks", (t1 - t0) / 20, 8);

        // R8: reload write while running does not touch the count
        cur_req = "R8";
        wr(2'd0, 8'hF8);
        idle(20);

        // R7: stop freezes count, wave low
        cur_req = "R7";
        wr(2'd1, 8'h20);
        idle(1);
        read_at(2'd2, c0);
        idle(10);
        read_at(2'd2, v); check("R7", "count frozen while stopped", v, c0);
        check("R7", "wave low when stopped", int'(wave), 0);

        // R10: count write ignored, addr 3 reads 0, spare ctrl bits read 0
        cur_req = "R10";
        wr(2'd2, 8'h5A);
        read_at(2'd2, v); check("R10", "count write ignored", v, c0);
        read_at(2'd3, v); check("R10", "addr 3 reads zero", v, 0);
        wr(2'd1, 8'hC0);
        read_at(2'd1, v); check("R10", "spare ctrl bits", v, 0);

        // R5: external clock mode
        cur_req = "R5";
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h09);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); ext_clk = 1'b1;
            idle(3 + p);
            @(negedge clk); ext_clk = 1'b0;
            idle(4);
        end
        idle(4);
        read_at(2'd2, v); check("R5", "one step per rising edge", v, 5);
        @(negedge clk); ext_clk = 1'b1;
        idle(30);
        read_at(2'd2, v); check("R5", "steady high gives one step", v, 6);
        @(negedge clk); ext_clk = 1'b0;
        idle(10);
        read_at(2'd2, v); check("R5", "falling edge gives no step", v, 6);
        wr(2'd1, 8'h08);
        idle(3);

        // R6: gated counting at full rate
        cur_req = "R6";
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h11);
        idle(12);
        read_at(2'd2, v); check("R6", "gate low blocks counting", v, 8'h10);
        @(negedge clk); gate = 1'b1;
        idle(9);
        @(negedge clk); gate = 1'b0;
        idle(8);
        read_at(2'd2, v); check("R6", "gate high window steps", v, 8'h10 + 10);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); gate = ~gate;
            idle(k);
        end
        @(negedge clk); gate = 1'b0;
        idle(6);
        wr(2'd1, 8'h00);
        idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule